// File: doc/BRIEF.md
# Host-to-User-Logic Handshake Bridge

This block lets a simple synchronous host bus reach user logic through a start/end handshake. It captures each host cycle's 4-bit location and direction. It presents them to the user side, then raises a start strobe. The host cycle is held in wait states for as long as the user logic needs. When the user logic returns its end strobe, the block issues a single-cycle acknowledge to the host. The wait has no time limit.

The host's direction pin polarity is a parameter. The user side always sees a read as a high flag, whatever the host uses. A separate active-low interrupt request from the user logic is forwarded to a host interrupt pin. It is independent of any transfer in flight. When the user logic runs on an unrelated clock, the end strobe and the interrupt each pass through a flop synchronizer of configurable depth. With direct (synchronous) user logic the synchronizers are replaced by wires.

The control is a five-state machine:
- **IDLE**: waits for a request. On a host request while end is low, it captures address and direction and moves to SETUP.
- **SETUP**: drives address and flag for one cycle, then moves to STROBE.
- **STROBE**: start is high. On end seen it moves to ACK.
- **ACK**: acknowledge is high for one cycle. It moves to DRAIN if end is still high, otherwise to IDLE.
- **DRAIN**: waits for end to fall, then returns to IDLE.

Top module: `ulink_bridge`

## Requirements
- R1: `usr_addr` carries the 4-bit `host_addr` captured when the cycle is accepted. `usr_rd` is 1 when `host_dir` equals parameter `RD_LEVEL` (a read) and 0 otherwise (a write).
- R2: Address and flag hold their transaction values for at least one clock before `usr_start` rises.
- R3: `usr_start` stays high until the end strobe is seen, and falls at the next clock edge. In direct mode, with end raised on the k-th cycle of start, start is high for exactly k cycles.
- R4: `host_ack` stays low for as long as end has not been seen, for any length of wait. In direct mode the acknowledge appears 2+k clocks after the host raises its request.
- R5: `host_ack` rises in the cycle right after end is seen with start high, and is exactly one clock wide.
- R6: `usr_addr` and `usr_rd` do not change from the first start cycle through the acknowledge cycle.
- R7: While the end input is high, no new host cycle is accepted and `usr_start` stays low. Once end falls, the pending request proceeds.
- R8: With `usr_start` wired straight back to `usr_end` in direct mode, a transfer completes with the acknowledge 3 clocks after the request.
- R9: `host_irq_n` follows `usr_irq_n` (active-low), whether or not a transfer is in flight. The delay is zero in direct mode and `SYNC_STAGES` clocks in asynchronous mode.
- R10: During reset `host_ack` and `usr_start` are 0, `usr_addr` and `usr_rd` are 0, and `host_irq_n` is inactive (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Host cycle request, held until acknowledge |
| host_dir | input | 1 | Host direction; equals RD_LEVEL for a read |
| host_addr | input | AW | Host user-location select |
| host_ack | output | 1 | One-cycle acknowledge ending the host wait |
| host_irq_n | output | 1 | Active-low interrupt toward the host |
| usr_addr | output | AW | Location presented to user logic |
| usr_rd | output | 1 | 1 = host read, 0 = host write |
| usr_start | output | 1 | Active-high start strobe |
| usr_end | input | 1 | Active-high end strobe from user logic |
| usr_irq_n | input | 1 | Active-low interrupt request from user logic |

## Verification
The assertions assume well-behaved user logic. It raises end only while start is high, or keeps end high continuously from a previous transfer; it never raises a fresh end in the SETUP cycle. They also assume the host holds its request until the acknowledge and drops it right after. The bench's user model raises end only after seeing start, or ties end to start in loopback mode. It releases a held end only while start is low. The host driver removes the request on the same half-cycle in which it sees the acknowledge.

// File: rtl/ulink_pkg.sv
`timescale 1ns/1ps
package ulink_pkg;

    // Handshake controller states
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a host request with end low
        ST_SETUP,   // address and flag driven, start still low
        ST_STROBE,  // start high, waiting for end
        ST_ACK,     // one-cycle host acknowledge
        ST_DRAIN    // end still high from previous transfer
    } ulink_state_e;

endpackage

// File: rtl/ulink_sync.sv
`timescale 1ns/1ps
// Optional flop chain for a signal crossing from user logic.
// STAGES == 0 gives a plain wire.
module ulink_sync #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_wire
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] sh;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh <= {STAGES{RST_VAL}};
                end else begin
                    sh[0] <= d;
                    for (int i = 1; i < int'(STAGES); i++) begin
                        sh[i] <= sh[i-1];
                    end
                end
            end

            assign q = sh[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ulink_fsm.sv
`timescale 1ns/1ps
module ulink_fsm
    import ulink_pkg::*;
#(
    parameter int unsigned AW       = 4,
    parameter bit          RD_LEVEL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_dir,
    input  logic [AW-1:0] host_addr,
    input  logic          end_s,
    output logic          host_ack,
    output logic [AW-1:0] usr_addr,
    output logic          usr_rd,
    output logic          usr_start
);

    ulink_state_e state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          rd_q;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && host_req && !end_s;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (end_s) state_d = ST_ACK;
            ST_ACK:    state_d = end_s ? ST_DRAIN : ST_IDLE;
            ST_DRAIN:  if (!end_s) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transaction capture, loaded only on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rd_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= host_addr;
            rd_q   <= (host_dir == RD_LEVEL);
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        usr_start = 1'b0;
        host_ack  = 1'b0;
        unique case (state_q)
            ST_STROBE: usr_start = 1'b1;
            ST_ACK:    host_ack  = 1'b1;
            default:   ;
        endcase
        usr_addr = addr_q;
        usr_rd   = rd_q;
    end

    // ---------------- assertions ----------------
    p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usr_start) |-> ($stable(usr_addr) && $stable(usr_rd)))
        else $error("R2: address or flag moved as start rose");

    p_hold_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_start && !end_s) |=> usr_start)
        else $error("R3: start dropped before end");

    p_drop_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_start && end_s) |=> (!usr_start && host_ack))
        else $error("R3/R5: start did not hand over to acknowledge");

    p_ack_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack)
        else $error("R5: acknowledge wider than one clock");

    p_ack_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> $past(end_s))
        else $error("R4: acknowledge without end");

    p_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(usr_start) && (usr_start || host_ack)) |-> ($stable(usr_addr) && $stable(usr_rd)))
        else $error("R6: address or flag changed during transfer");

    p_no_start_on_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usr_start) |-> !$past(end_s))
        else $error("R7: start rose while end was high");

endmodule

// File: rtl/ulink_bridge.sv
`timescale 1ns/1ps
module ulink_bridge #(
    parameter int unsigned AW          = 4,
    parameter bit          RD_LEVEL    = 1'b1,
    parameter bit          ASYNC_USER  = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_dir,
    input  logic [AW-1:0] host_addr,
    output logic          host_ack,
    output logic          host_irq_n,
    output logic [AW-1:0] usr_addr,
    output logic          usr_rd,
    output logic          usr_start,
    input  logic          usr_end,
    input  logic          usr_irq_n
);

    localparam int unsigned XSTAGES = ASYNC_USER ? SYNC_STAGES : 0;

    logic end_s;

    ulink_sync #(.STAGES(XSTAGES), .RST_VAL(1'b0)) u_end_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (usr_end),
        .q     (end_s)
    );

    ulink_sync #(.STAGES(XSTAGES), .RST_VAL(1'b1)) u_irq_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (usr_irq_n),
        .q     (host_irq_n)
    );

    ulink_fsm #(.AW(AW), .RD_LEVEL(RD_LEVEL)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (host_req),
        .host_dir  (host_dir),
        .host_addr (host_addr),
        .end_s     (end_s),
        .host_ack  (host_ack),
        .usr_addr  (usr_addr),
        .usr_rd    (usr_rd),
        .usr_start (usr_start)
    );

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!host_ack && !usr_start))
        else $error("R10: outputs active after reset");

endmodule

// File: tb/ulink_bridge_bench.sv
`timescale 1ns/1ps
module ulink_bridge_bench;

    localparam int  AW     = 4;
    localparam bit  RD_LVL = 1'b0;   // host drives 0 for a read

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;            // 250 MHz

    logic          host_req = 1'b0;
    logic          host_dir = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_ack, host_irq_n;
    logic [AW-1:0] usr_addr;
    logic          usr_rd, usr_start, usr_end;
    logic          usr_irq_n = 1'b1;

    logic loop_mode = 1'b0;
    logic keep_end  = 1'b0;
    logic end_drv   = 1'b0;
    assign usr_end = loop_mode ? usr_start : end_drv;

    ulink_bridge #(.AW(AW), .RD_LEVEL(RD_LVL), .ASYNC_USER(1'b0), .SYNC_STAGES(2)) u_ulink_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_dir(host_dir), .host_addr(host_addr),
        .host_ack(host_ack), .host_irq_n(host_irq_n),
        .usr_addr(usr_addr), .usr_rd(usr_rd), .usr_start(usr_start),
        .usr_end(usr_end), .usr_irq_n(usr_irq_n)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    typedef struct {
        logic [AW-1:0] a;
        logic          rd;
        int            dly;
    } item_t;
    item_t exp_q[$];

    // monitor and user-side responder
    logic          prev_start = 1'b0;
    logic [AW-1:0] prev_addr  = '0;
    logic          prev_rd    = 1'b0;
    int            hi_cnt     = 0;
    item_t         cur        = '{a: '0, rd: 1'b0, dly: 1};

    always @(negedge clk) begin
        if (rst_n) begin
            if (usr_start && !prev_start) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected start", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                    check("R1 address", int'(usr_addr), int'(cur.a));
                    check("R1 read flag", int'(usr_rd), int'(cur.rd));
                    check("R2 address before start", int'(prev_addr), int'(cur.a));
                    check("R2 flag before start", int'(prev_rd), int'(cur.rd));
                end
                hi_cnt = 0;
            end
            if (usr_start) begin
                hi_cnt++;
                check("R4 no ack while waiting", int'(host_ack), 0);
                check("R6 address during start", int'(usr_addr), int'(cur.a));
                if (hi_cnt >= cur.dly) end_drv = 1'b1;
            end
            if (!usr_start && prev_start) begin
                check("R3 start width", hi_cnt, cur.dly);
                check("R5 ack follows end", int'(host_ack), 1);
                check("R6 address at ack", int'(usr_addr), int'(cur.a));
                check("R6 flag at ack", int'(usr_rd), int'(cur.rd));
            end
            if (!usr_start && !keep_end) end_drv = 1'b0;
            prev_start = usr_start;
            prev_addr  = usr_addr;
            prev_rd    = usr_rd;
        end
    end

    // host driver
    task automatic host_cycle(input logic [AW-1:0] a, input logic rd, input int dly,
                              input bit chk_lat, input string tag);
        int n;
        exp_q.push_back('{a: a, rd: rd, dly: dly});
        @(negedge clk);
        host_addr = a;
        host_dir  = rd ? RD_LVL : ~RD_LVL;
        host_req  = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!host_ack && n < 2000);
        if (chk_lat) check(tag, n, 2 + dly);
        host_req = 1'b0;
        @(negedge clk);
        check("R5 ack one cycle", int'(host_ack), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        // R10 reset state
        repeat (3) @(negedge clk);
        check("R10 ack in reset", int'(host_ack), 0);
        check("R10 start in reset", int'(usr_start), 0);
        check("R10 addr in reset", int'(usr_addr), 0);
        check("R10 flag in reset", int'(usr_rd), 0);
        check("R10 irq in reset", int'(host_irq_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1/R4 various patterns
        host_cycle(4'hA, 1'b1, 1, 1'b1, "R4 latency d1");
        host_cycle(4'h5, 1'b0, 3, 1'b1, "R4 latency d3");
        host_cycle(4'hF, 1'b1, 2, 1'b1, "R4 latency d2");
        host_cycle(4'h0, 1'b0, 1, 1'b1, "R4 latency addr0");
        // R4 long wait
        host_cycle(4'h7, 1'b1, 40, 1'b1, "R4 latency long wait");

        // R8 loopback
        loop_mode = 1'b1;
        host_cycle(4'hC, 1'b0, 1, 1'b1, "R8 loopback latency");
        host_cycle(4'h3, 1'b1, 1, 1'b1, "R8 loopback back-to-back");
        loop_mode = 1'b0;

        // R7 end held high after a transfer
        keep_end = 1'b1;
        host_cycle(4'h6, 1'b1, 2, 1'b1, "R4 latency before hold");
        exp_q.push_back('{a: 4'h9, rd: 1'b0, dly: 1});
        @(negedge clk);
        host_addr = 4'h9;
        host_dir  = ~RD_LVL;
        host_req  = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R7 start blocked while end high", int'(usr_start), 0);
            check("R7 no ack while end high", int'(host_ack), 0);
        end
        keep_end = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!host_ack && n < 2000);
        check("R7 pending cycle completes", int'(host_ack), 1);
        host_req = 1'b0;
        @(negedge clk);

        // R9 interrupt pass-through
        usr_irq_n = 1'b0;
        #1 check("R9 irq asserted", int'(host_irq_n), 0);
        host_cycle(4'h2, 1'b1, 4, 1'b1, "R4 latency with irq pending");
        check("R9 irq held through transfer", int'(host_irq_n), 0);
        usr_irq_n = 1'b1;
        #1 check("R9 irq released", int'(host_irq_n), 1);

        repeat (3) @(negedge clk);
        check("R1 all expected starts seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule